// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the memory-mapped control and bookkeeping registers that sit beside an address-translation unit: a translation control word, the high and low halves of a page-table entry being built, a small entry-assist field, the translation table base, the faulting address, the trap code, and the exception and interrupt event codes. Some writes have side effects. They send one-cycle pulses to an external TLB. A control write with the invalidate bit set requests a full invalidate. A write to the entry-high register that changes the address-space identifier (ASID, its low 8 bits) requests a flush. The bank also holds a 16-bit refresh counter that advances each time it is read.

Software reaches the bank over a simple request/response port. The request carries a register index (`req_addr`) and an access size. The response comes exactly one cycle later. A register accessed at the wrong size, or an index with no register behind it, gives an error response and changes no state.

Top module: `mmu_ctl_bank`

## Requirements
- R1: A word write to index 0 (control) with bit 2 set asserts `tlb_inval` for the one cycle after the write. Bit 2 is never stored and always reads 0. All other bits are stored as written.
- R2: A word write to index 1 (entry high) whose bits [7:0] differ from the stored bits [7:0] asserts `tlb_flush` for the one cycle after the write. The full 32-bit value is stored.
- R3: Index 3 (entry assist) keeps only write bits [3:0]. The upper bits read 0.
- R4: Indices 6, 7 and 8 (trap code, exception event, interrupt event) keep only write bits [10:0]. The upper bits read 0.
- R5: Indices 2, 4 and 5 (entry low, table base, fault address) store and return all 32 bits.
- R6: Index 9 is the 16-bit refresh counter. A half-word read returns the current value (upper 16 bits 0) and then increments it, wrapping from 0xFFFF to 0. A half-word write loads it.
- R7: An access at the wrong size raises `rsp_err` and returns data 0. It changes no register and raises no pulse. Indices 0–8 need size 2 (word) and index 9 needs size 1 (half); sizes 0 and 3 are always wrong.
- R8: After reset every register reads 0 and no pulse is asserted. `rsp_valid` follows `req_valid` by exactly one cycle.
- R9: An access to any index above 9 raises `rsp_err` and returns data 0.
- R10: A word write to index 1 whose bits [7:0] equal the stored bits [7:0] raises no flush pulse. The full value is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register index |
| req_size | input | 2 | 1 = half word, 2 = word, other values invalid |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access error (wrong size or unmapped index) |
| rsp_rdata | output | 32 | Read data, 0 on writes and errors |
| tlb_inval | output | 1 | One-cycle full TLB invalidate request |
| tlb_flush | output | 1 | One-cycle TLB flush on ASID change |

## Verification
Several cases are hard to reach from the ports. The first is a flush request caused only by a change in the ASID byte: the stimulus writes entry-high twice with the same low byte and different upper bits, which must give no pulse, and then changes only the low byte. The second is counter wrap: the counter is loaded with 0xFFFF, so the next two reads must return 0xFFFF and then 0. The third is an invalidate write sent at the wrong size. It must produce an error, no pulse, and leave the control register's read-back unchanged.

// File: rtl/mmu_bank_pkg.sv
package mmu_bank_pkg;
  localparam int NREG = 9;

  typedef enum logic [3:0] {
    IX_CTL     = 4'd0,
    IX_PTEH    = 4'd1,
    IX_PTEL    = 4'd2,
    IX_ASSIST  = 4'd3,
    IX_TBASE   = 4'd4,
    IX_EXCADDR = 4'd5,
    IX_TRAP    = 4'd6,
    IX_EXCEVT  = 4'd7,
    IX_INTEVT  = 4'd8,
    IX_RCNT    = 4'd9
  } reg_ix_e;

  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/mmu_bank_decode.sv
module mmu_bank_decode
  import mmu_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              is_cnt,
  output logic              acc_ok
);
  logic in_file;

  always_comb begin
    in_file = (addr < ADDR_W'(NREG));
    is_cnt  = (addr == ADDR_W'(IX_RCNT));
    acc_ok  = (in_file && size == SZ_WORD) || (is_cnt && size == SZ_HALF);
  end
endmodule

// File: rtl/mmu_bank_regfile.sv
module mmu_bank_regfile
  import mmu_bank_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int INVAL_BIT = 2,
  parameter int ASID_W    = 8,
  parameter int ASSIST_W  = 4,
  parameter int EVT_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ASID_W-1:0] asid_q
);
  logic [DATA_W-1:0] regs [NREG];

  function automatic logic [DATA_W-1:0] keep_of(int ix);
    logic [DATA_W-1:0] m;
    m = '0;
    case (ix)
      int'(IX_CTL): begin
        m = '1;
        m[INVAL_BIT] = 1'b0;
      end
      int'(IX_ASSIST): m[ASSIST_W-1:0] = '1;
      int'(IX_TRAP), int'(IX_EXCEVT), int'(IX_INTEVT): m[EVT_W-1:0] = '1;
      default: m = '1;
    endcase
    return m;
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP = keep_of(g);
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (wr_en && idx == ADDR_W'(g)) regs[g] <= wdata & KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == ADDR_W'(i)) rdata = regs[i];
  end

  assign asid_q = regs[int'(IX_PTEH)][ASID_W-1:0];
endmodule

// File: rtl/mmu_bank_refcnt.sv
module mmu_bank_refcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             inc,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  // R6: every accepted read advances the count by one
  p_read_advances_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inc) && !$past(ld)) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/mmu_ctl_bank.sv
module mmu_ctl_bank
  import mmu_bank_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int INVAL_BIT = 2,
  parameter int ASID_W    = 8,
  parameter int ASSIST_W  = 4,
  parameter int EVT_W     = 11,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tlb_inval,
  output logic              tlb_flush
);
  logic              is_cnt, acc_ok, wr_en, rd_en;
  logic [DATA_W-1:0] file_rdata;
  logic [ASID_W-1:0] asid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              inval_d, flush_d;

  mmu_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .size(req_size), .is_cnt(is_cnt), .acc_ok(acc_ok)
  );

  assign wr_en = req_valid && acc_ok && req_write;
  assign rd_en = req_valid && acc_ok && !req_write;

  mmu_bank_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INVAL_BIT(INVAL_BIT),
    .ASID_W(ASID_W), .ASSIST_W(ASSIST_W), .EVT_W(EVT_W)
  ) u_file (
    .clk(clk), .rst(rst), .wr_en(wr_en && !is_cnt), .idx(req_addr),
    .wdata(req_wdata), .rdata(file_rdata), .asid_q(asid_q)
  );

  mmu_bank_refcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ld(wr_en && is_cnt), .inc(rd_en && is_cnt),
    .ld_val(req_wdata[CNT_W-1:0]), .cnt_q(cnt_q)
  );

  assign inval_d = wr_en && req_addr == ADDR_W'(IX_CTL) && req_wdata[INVAL_BIT];
  assign flush_d = wr_en && req_addr == ADDR_W'(IX_PTEH) &&
                   req_wdata[ASID_W-1:0] != asid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      tlb_inval <= 1'b0;
      tlb_flush <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      tlb_inval <= inval_d;
      tlb_flush <= flush_d;
      if (rd_en) rsp_rdata <= is_cnt ? DATA_W'(cnt_q) : file_rdata;
      else       rsp_rdata <= '0;
    end
  end

  // R8: response follows request by one cycle
  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsp_valid == $past(req_valid));
  // R1: invalidate pulse only after a control write carrying the bit
  p_inval_cause_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tlb_inval) |->
      ($past(req_valid) && $past(req_write) && $past(req_size) == SZ_WORD &&
       $past(req_addr) == ADDR_W'(IX_CTL) && $past(req_wdata[INVAL_BIT])));
  // R2 / R10: flush pulse only after an entry-high write
  p_flush_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tlb_flush) |->
      ($past(req_valid) && $past(req_write) && $past(req_addr) == ADDR_W'(IX_PTEH)));
  // R1: a control read never shows the invalidate bit
  p_ctl_bit_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(req_addr) == ADDR_W'(IX_CTL))
      |-> !rsp_rdata[INVAL_BIT]);
  // R7: an error response carries no data and no pulse
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0 && !tlb_inval && !tlb_flush));
  // R4: event code reads keep upper bits clear
  p_evt_width_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(req_addr) >= ADDR_W'(IX_TRAP) &&
     $past(req_addr) <= ADDR_W'(IX_INTEVT)) |-> rsp_rdata[DATA_W-1:EVT_W] == '0);
endmodule

// File: tb/mmu_ctl_bank_tb.sv
module mmu_ctl_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, tlb_inval, tlb_flush;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;
  logic [31:0] rd;
  logic        er, inv, fl, vl;

  always #2 clk = ~clk;

  mmu_ctl_bank u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .tlb_inval(tlb_inval), .tlb_flush(tlb_flush)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [3:0] a,
                     input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    rd = rsp_rdata; er = rsp_err; inv = tlb_inval; fl = tlb_flush; vl = rsp_valid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 9; i++) begin
      acc(1'b0, 2'd2, 4'(i), '0);
      chk("R8 reset value", rd, 32'h0);
      chk("R8 no error", {31'b0, er}, 32'h0);
    end
    acc(1'b0, 2'd1, 4'd9, '0);
    chk("R8 counter reset", rd, 32'h0);
    chk("R8 rsp_valid", {31'b0, vl}, 32'h1);
    @(posedge clk); #1;
    chk("R8 rsp_valid drops", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_ctl();
    acc(1'b1, 2'd2, 4'd0, 32'hA5A5_FFFF);
    chk("R1 inval pulse", {31'b0, inv}, 32'h1);
    @(posedge clk); #1;
    chk("R1 pulse one cycle", {31'b0, tlb_inval}, 32'h0);
    acc(1'b0, 2'd2, 4'd0, '0);
    chk("R1 bit2 reads 0", rd, 32'hA5A5_FFFB);
    acc(1'b1, 2'd2, 4'd0, 32'h0000_0011);
    chk("R1 no pulse when bit clear", {31'b0, inv}, 32'h0);
  endtask

  task automatic t_pteh();
    acc(1'b1, 2'd2, 4'd1, 32'h1234_5600);
    chk("R10 same ASID no flush", {31'b0, fl}, 32'h0);
    acc(1'b0, 2'd2, 4'd1, '0);
    chk("R10 stored full", rd, 32'h1234_5600);
    acc(1'b1, 2'd2, 4'd1, 32'h1234_5642);
    chk("R2 flush on ASID change", {31'b0, fl}, 32'h1);
    @(posedge clk); #1;
    chk("R2 flush one cycle", {31'b0, tlb_flush}, 32'h0);
    acc(1'b0, 2'd2, 4'd1, '0);
    chk("R2 stored full", rd, 32'h1234_5642);
    acc(1'b1, 2'd2, 4'd1, 32'hFFFF_0042);
    chk("R10 upper change no flush", {31'b0, fl}, 32'h0);
  endtask

  task automatic t_masks();
    acc(1'b1, 2'd2, 4'd3, 32'hFFFF_FFFF);
    acc(1'b0, 2'd2, 4'd3, '0);
    chk("R3 assist 4 bits", rd, 32'h0000_000F);
    for (int i = 6; i <= 8; i++) begin
      acc(1'b1, 2'd2, 4'(i), 32'hDEAD_BEEF);
      acc(1'b0, 2'd2, 4'(i), '0);
      chk("R4 event 11 bits", rd, 32'h0000_06EF);
    end
    acc(1'b1, 2'd2, 4'd2, 32'hCAFE_F00D);
    acc(1'b1, 2'd2, 4'd4, 32'h8000_0001);
    acc(1'b1, 2'd2, 4'd5, 32'hFFFF_FFFF);
    acc(1'b0, 2'd2, 4'd2, '0); chk("R5 entry low", rd, 32'hCAFE_F00D);
    acc(1'b0, 2'd2, 4'd4, '0); chk("R5 table base", rd, 32'h8000_0001);
    acc(1'b0, 2'd2, 4'd5, '0); chk("R5 fault addr", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_cnt();
    acc(1'b0, 2'd1, 4'd9, '0); chk("R6 read current", rd, 32'h1);
    acc(1'b0, 2'd1, 4'd9, '0); chk("R6 incremented", rd, 32'h2);
    acc(1'b1, 2'd1, 4'd9, 32'hABCD_FFFF);
    acc(1'b0, 2'd1, 4'd9, '0); chk("R6 load", rd, 32'h0000_FFFF);
    acc(1'b0, 2'd1, 4'd9, '0); chk("R6 wrap", rd, 32'h0);
  endtask

  task automatic t_errors();
    acc(1'b1, 2'd1, 4'd0, 32'hFFFF_FFFF);
    chk("R7 half to ctl error", {31'b0, er}, 32'h1);
    chk("R7 no pulse on error", {30'b0, inv, fl}, 32'h0);
    acc(1'b0, 2'd2, 4'd0, '0);
    chk("R7 ctl unchanged", rd, 32'h0000_0011);
    acc(1'b1, 2'd2, 4'd9, 32'h0000_0055);
    chk("R7 word to counter error", {31'b0, er}, 32'h1);
    acc(1'b0, 2'd0, 4'd4, '0);
    chk("R7 byte read error", {31'b0, er}, 32'h1);
    chk("R7 error data zero", rd, 32'h0);
    acc(1'b0, 2'd1, 4'd9, '0);
    chk("R7 counter unchanged", rd, 32'h1);
    acc(1'b1, 2'd2, 4'd12, 32'h1);
    chk("R9 unmapped write error", {31'b0, er}, 32'h1);
    acc(1'b0, 2'd2, 4'd15, '0);
    chk("R9 unmapped read error", {31'b0, er}, 32'h1);
    chk("R9 unmapped data zero", rd, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_ctl();
        t_pteh();
        t_masks();
        t_cnt();
        t_errors();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule